// File: doc/BRIEF.md
# Smartcard Block Reception Wait Timer

This block watches the receive side of a block-oriented smartcard exchange. It has two parts. The first is a down-counting wait timer that counts bit-time ticks. Software loads it with the response wait budget before it asks the card for a block. Each end-of-character strobe then reloads it with the inter-character budget that software has placed on the value input by then. When the budget runs out before the next character ends, the timer raises a sticky timeout flag and stops counting.

The second part is a received-character counter. It is cleared for as long as the local transmitter is busy. It pulses once for the first character of a block. It pulses once more at end of block, when the count reaches the programmed length plus four. The four extra characters are three prologue bytes and one epilogue byte. The length input can be rewritten while the block is arriving, normally with the length byte taken from the third character.

Software is expected to drive the value input with the wait budget minus 11. The block counts that value exactly as given. Character deserialisation takes place outside this block.

Top module: `sc_block_timer`

## Requirements
- R1: After reset, timeout_o, first_char_o and blk_end_o are all low.
- R2: A load with value N (N >= 1) sets timeout_o high one clock after the N-th subsequent bit tick. A load with N = 0 behaves as N = 1. A load also clears a pending timeout flag.
- R3: An end-of-character strobe restarts the timer from the current value input. In a cycle where it coincides with a bit tick, the tick is discarded.
- R4: Once set, timeout_o stays high and the timer stops counting until a clear or a load. A clear drops timeout_o one clock later.
- R5: first_char_o pulses for one clock, one clock after the first character-received strobe that follows a counter reset.
- R6: While tx_active_i is high, the character count is held at zero and character strobes are ignored. The next character after release is therefore a first character again.
- R7: blk_end_o pulses for one clock, one clock after the character that brings the count to blk_len_i + 4. With blk_len_i = 0 this is the 4th character.
- R8: After end of block the count saturates: further characters produce no pulse on either output until tx_active_i resets the count.
- R9: A new blk_len_i value applies to every character from the next one onward, including in the middle of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| char_rx_i | input | 1 | Character received strobe |
| char_end_i | input | 1 | End of received character strobe |
| tx_active_i | input | 1 | Transmit buffer not empty; holds the character count at zero |
| tmo_load_i | input | 1 | Software load of the wait timer |
| tmo_clr_i | input | 1 | Software clear of the timeout flag |
| tmo_val_i | input | 24 | Wait budget in bit times |
| blk_len_i | input | 8 | Block length taken from the prologue |
| timeout_o | output | 1 | Sticky timeout flag |
| first_char_o | output | 1 | First-character pulse |
| blk_end_o | output | 1 | End-of-block pulse |

## Verification
Every result is registered once. The timeout flag, the first-character pulse and the end-of-block pulse therefore all appear exactly one clock after the input strobe that causes them. The driver applies each stimulus one time step after a rising edge. Before it releases the edge that captures a stimulus, it queues the expected event tagged with that edge's cycle number. The monitor samples on the falling edge and compares each event it sees with the head of the queue by kind and by cycle, so an event that comes early, comes late or was never queued is reported. Level properties, namely the held flag, its clear, and the silence after saturation or after a stopped timer, are read directly from the ports between edges.

// File: rtl/sc_blk_pkg.sv
package sc_blk_pkg;
  localparam int unsigned TMO_W     = 24;
  localparam int unsigned LEN_W     = 8;
  localparam int unsigned HDR_CHARS = 4; // 3 prologue + 1 epilogue
endpackage

// File: rtl/sc_wait_timer.sv
module sc_wait_timer #(
  parameter int unsigned W = sc_blk_pkg::TMO_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic         reload_i,
  input  logic         clr_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;
  logic         exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= val_i;
      run_q <= 1'b1;
      exp_q <= 1'b0;
    end else begin
      if (clr_i) exp_q <= 1'b0;
      if (reload_i) begin
        cnt_q <= val_i;
        run_q <= 1'b1;
      end else if (run_q && tick_i) begin
        if (cnt_q <= W'(1)) begin
          cnt_q <= '0;
          run_q <= 1'b0;
          exp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - W'(1);
        end
      end
    end
  end

  assign expired_o = exp_q;

  p_flag_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q && !clr_i && !load_i |=> exp_q);
  p_load_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !exp_q);
  p_stopped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !load_i && !reload_i |=> $stable(cnt_q) && !run_q);
endmodule

// File: rtl/sc_char_counter.sv
module sc_char_counter #(
  parameter int unsigned LEN_W = sc_blk_pkg::LEN_W,
  parameter int unsigned HDR   = sc_blk_pkg::HDR_CHARS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             tx_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             first_o,
  output logic             end_o
);
  localparam int unsigned CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, target;
  logic             done_q, first_q, end_q;

  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign target  = CNT_W'(len_i) + CNT_W'(HDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      first_q <= 1'b0;
      end_q   <= 1'b0;
    end else if (tx_i) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      first_q <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      first_q <= rx_i && (cnt_q == '0) && !done_q;
      end_q   <= 1'b0;
      if (rx_i && !done_q) begin
        cnt_q <= cnt_nxt;
        // >= covers a length lowered below the running count
        if (cnt_nxt >= target) begin
          done_q <= 1'b1;
          end_q  <= 1'b1;
        end
      end
    end
  end

  assign first_o = first_q;
  assign end_o   = end_q;

  p_tx_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_i |=> !first_q && !end_q && (cnt_q == '0));
  p_saturate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !tx_i |=> $stable(cnt_q) && !end_q && !first_q);
  p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({first_q, end_q}));
endmodule

// File: rtl/sc_block_timer.sv
module sc_block_timer #(
  parameter int unsigned TMO_W = sc_blk_pkg::TMO_W,
  parameter int unsigned LEN_W = sc_blk_pkg::LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             char_rx_i,
  input  logic             char_end_i,
  input  logic             tx_active_i,
  input  logic             tmo_load_i,
  input  logic             tmo_clr_i,
  input  logic [TMO_W-1:0] tmo_val_i,
  input  logic [LEN_W-1:0] blk_len_i,
  output logic             timeout_o,
  output logic             first_char_o,
  output logic             blk_end_o
);
  sc_wait_timer #(.W(TMO_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (bit_tick_i),
    .load_i    (tmo_load_i),
    .reload_i  (char_end_i),
    .clr_i     (tmo_clr_i),
    .val_i     (tmo_val_i),
    .expired_o (timeout_o)
  );

  sc_char_counter #(.LEN_W(LEN_W), .HDR(sc_blk_pkg::HDR_CHARS)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_i    (char_rx_i),
    .tx_i    (tx_active_i),
    .len_i   (blk_len_i),
    .first_o (first_char_o),
    .end_o   (blk_end_o)
  );

  p_clr_drops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_clr_i && timeout_o && !bit_tick_i |=> !timeout_o);
  p_no_pulse_tx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_i |=> !first_char_o && !blk_end_o);
endmodule

// File: tb/tb_sc_block_timer.sv
module tb_sc_block_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 0, rx = 0, cend = 0, txa = 0, ld = 0, clr = 0;
  logic [23:0] val = '0;
  logic [7:0]  len = '0;
  logic        tmo, first, bend;

  int checks = 0, fails = 0, cyc = 0;
  logic prev_tmo = 1'b0;

  typedef struct {int kind; int at; string tag;} ev_t;
  ev_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sc_block_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .char_rx_i(rx),
    .char_end_i(cend), .tx_active_i(txa), .tmo_load_i(ld), .tmo_clr_i(clr),
    .tmo_val_i(val), .blk_len_i(len), .timeout_o(tmo),
    .first_char_o(first), .blk_end_o(bend)
  );

  task automatic expect_ev(int kind, string tag);
    ev_t e;
    e.kind = kind; e.at = cyc + 1; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk(logic cond, string tag, int act, int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic next();
    @(posedge clk); #1;
    tick = 0; rx = 0; cend = 0; ld = 0; clr = 0;
  endtask

  task automatic observe(int kind);
    ev_t e;
    checks++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL unexpected event actual=kind%0d@%0d expected=none", kind, cyc);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        fails++;
        $display("FAIL %s actual=kind%0d@%0d expected=kind%0d@%0d",
                 e.tag, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor: order timeout, first, end
  always @(negedge clk) if (rst_n) begin
    if (tmo && !prev_tmo) observe(0);
    if (first) observe(1);
    if (bend) observe(2);
    prev_tmo = tmo;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(tmo == 0 && first == 0 && bend == 0, "R1 reset outputs", {tmo, first, bend}, 0);
    rst_n = 1'b1;
    next();

    // R2: load 5, expire on 5th tick
    ld = 1; val = 24'd5; next();
    for (int i = 1; i <= 5; i++) begin
      tick = 1;
      if (i == 5) expect_ev(0, "R2 timeout after N ticks");
      next(); next();
    end
    // R4: hold while stopped
    for (int i = 0; i < 3; i++) begin tick = 1; next(); end
    chk(tmo == 1, "R4 flag held", tmo, 1);
    clr = 1; next();
    chk(tmo == 0, "R4 clear drops flag", tmo, 0);
    for (int i = 0; i < 6; i++) begin tick = 1; next(); end
    chk(tmo == 0, "R4 stopped timer stays quiet", tmo, 0);

    // R3: reload on char_end, coinciding tick discarded
    ld = 1; val = 24'd3; next();
    tick = 1; next();
    tick = 1; next();
    tick = 1; cend = 1; next();
    tick = 1; next();
    tick = 1; next();
    chk(tmo == 0, "R3 reload restarted count", tmo, 0);
    tick = 1; expect_ev(0, "R3 timeout after reload"); next();
    next();
    clr = 1; next();
    // R2: N=0 acts as 1
    ld = 1; val = 24'd0; next();
    tick = 1; expect_ev(0, "R2 zero load expires first tick"); next();
    next();
    ld = 1; val = 24'd9; next();
    chk(tmo == 0, "R2 load clears flag", tmo, 0);

    // block counter, len 0
    txa = 1; next(); txa = 0; len = 8'd0;
    for (int i = 1; i <= 4; i++) begin
      rx = 1;
      if (i == 1) expect_ev(1, "R5 first char pulse");
      if (i == 4) expect_ev(2, "R7 end at 4th char len0");
      next(); next();
    end
    // R8: saturated
    for (int i = 0; i < 2; i++) begin rx = 1; next(); next(); end
    chk(bend == 0 && first == 0, "R8 saturated silence", {first, bend}, 0);
    // R6: char during tx ignored
    txa = 1; rx = 1; next(); next();
    chk(first == 0 && bend == 0, "R6 no pulse during tx", {first, bend}, 0);
    txa = 0; next();
    len = 8'd6;
    rx = 1; expect_ev(1, "R6 count reset by tx"); next(); next();
    rx = 1; next(); next();
    rx = 1; next(); next();
    len = 8'd1; // R9: target becomes 5
    rx = 1; next(); next();
    chk(bend == 0, "R9 no end at 4th char", bend, 0);
    rx = 1; expect_ev(2, "R9 end with updated length"); next(); next();
    next(); next();

    checks++;
    if (q.size() != 0) begin
      fails++;
      while (q.size() != 0) begin
        ev_t e = q.pop_front();
        $display("FAIL %s actual=missing expected=kind%0d@%0d", e.tag, e.kind, e.at);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule